// File: doc/BRIEF.md
# Serial Channel Command and Status Control

This block is the host-facing control logic of a single serial channel. A host writes command bytes that switch the receiver and transmitter on or off and run channel reset commands. The block keeps the channel status byte and a small file of mode registers that the host reaches through a self-advancing pointer. Transmit-holding writes go to a byte output only while the transmitter reports ready.

The receive path, the serialiser and the baud logic live outside the block. They report receive and error events through single-cycle set inputs. The block holds the channel's transmit-ready and break-change interrupt requests as level outputs, and it presents the mode register contents to the serialiser.

Top module: `uart_chan_ctrl`

## Requirements
- R1: After reset the receiver and transmitter are off, the status byte reads 0x00, the mode pointer selects the first mode register, and both interrupt outputs are low.
- R2: In a command byte, bit 0 turns the receiver on and bit 1 turns it off. When both are set in one write, off wins.
- R3: Command bit 2 sets status bit 2 (transmit ready), status bit 3 (transmitter empty) and `tx_irq`. Command bit 3 clears all three, and it wins over bit 2 in the same write.
- R4: A mode register read or write (`reg_sel`=0) uses the current pointer and then moves it to the second register, where it stays. Command code 1 (bits 7:4) returns it to the first register. `mode_cfg[7:0]` is the first register and `mode_cfg[15:8]` the second.
- R5: Command code 2 turns the receiver off and clears status bits 0 (receive ready) and 1 (receive full).
- R6: Command code 3 clears status bits 2 and 3 and `tx_irq`. It acts after the enable bits of the same byte.
- R7: Command code 4 clears status bits 7:4. An error event on `err_set[3:0]` (bits 4..7) in the same cycle still sets its bit.
- R8: Command code 5 clears `brk_irq`. A `brk_set` pulse in the same cycle leaves it set.
- R9: Command codes 0 and 6 to 15 change no state.
- R10: A holding write (`reg_sel`=2) made while status bit 2 is set produces `tx_valid` high for exactly one clock, in the cycle after the write, with the byte on `tx_data`. Without bit 2 the byte is dropped.
- R11: With `reg_sel`=1, a write is a command and a read returns the status byte. Writes with `reg_sel`=3 are ignored. Reads with `reg_sel` 2 or 3 return 0.
- R12: `rx_set[0]` and `rx_set[1]` set status bits 0 and 1, and `err_set` sets bits 4 to 7. These bits stay set until a command clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| reg_sel | input | 2 | Register select: 0 mode, 1 command/status, 2 holding, 3 none |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Host read byte (combinational) |
| rx_set | input | 2 | Receive-ready / receive-full event pulses |
| err_set | input | 4 | Overrun, parity, framing, break event pulses |
| brk_set | input | 1 | Break-change event pulse |
| rx_en | output | 1 | Receiver enabled |
| tx_irq | output | 1 | Transmit-ready interrupt request |
| brk_irq | output | 1 | Break-change interrupt request |
| mode_cfg | output | 16 | Mode registers, first in low byte |
| tx_valid | output | 1 | Accepted transmit byte strobe |
| tx_data | output | 8 | Accepted transmit byte |

## Verification
Two functions can land on the same clock edge: a clearing command (reset-error or reset-break-change), and an incoming error or break event that sets the same bit. The bench drives the command write and the event pulse on the same edge. It then judges by the status byte and `brk_irq` that only the new event's bit remains. The bench also drives enable and disable, or enable and reset, in one command byte, to confirm that the later action wins.

// File: rtl/chan_ctrl_pkg.sv
package chan_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_MODE = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_HOLD = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [3:0] {
    OP_NONE    = 4'd0,
    OP_PTR_RST = 4'd1,
    OP_RX_RST  = 4'd2,
    OP_TX_RST  = 4'd3,
    OP_ERR_RST = 4'd4,
    OP_BRK_RST = 4'd5
  } cmd_op_e;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_rst;
    logic rx_rst;
    logic err_rst;
    logic brk_rst;
  } cmd_act_t;

  localparam int ST_RXRDY = 0;
  localparam int ST_FULL  = 1;
  localparam int ST_TXRDY = 2;
  localparam int ST_TXEMT = 3;
  localparam int ST_ERR_LO = 4;
endpackage

// File: rtl/chan_cmd_decode.sv
module chan_cmd_decode
  import chan_ctrl_pkg::*;
(
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  output cmd_act_t   act
);
  cmd_op_e op;

  always_comb begin
    op          = cmd_op_e'(cmd_byte[7:4]);
    act         = '0;
    if (cmd_we) begin
      act.rx_on   = cmd_byte[0];
      act.rx_off  = cmd_byte[1];
      act.tx_on   = cmd_byte[2];
      act.tx_off  = cmd_byte[3] || (op == OP_TX_RST);
      act.ptr_rst = (op == OP_PTR_RST);
      act.rx_rst  = (op == OP_RX_RST);
      act.err_rst = (op == OP_ERR_RST);
      act.brk_rst = (op == OP_BRK_RST);
    end
  end
endmodule

// File: rtl/chan_status.sv
module chan_status
  import chan_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_act_t          act,
  input  logic [1:0]        rx_set,
  input  logic [ERR_W-1:0]  err_set,
  input  logic              brk_set,
  output logic [DATA_W-1:0] status_q,
  output logic              rx_en_q,
  output logic              tx_irq_q,
  output logic              brk_irq_q
);
  localparam int ERR_HI = ST_ERR_LO + ERR_W - 1;

  logic [DATA_W-1:0] status_d;
  logic              rx_en_d, tx_irq_d, brk_irq_d;
  logic              upd_en;

  always_comb begin
    status_d  = status_q;
    rx_en_d   = rx_en_q;
    tx_irq_d  = tx_irq_q;
    brk_irq_d = brk_irq_q;
    // receiver switch: on, then off, then reset
    if (act.rx_on)  rx_en_d = 1'b1;
    if (act.rx_off) rx_en_d = 1'b0;
    if (act.rx_rst) begin
      rx_en_d            = 1'b0;
      status_d[ST_RXRDY] = 1'b0;
      status_d[ST_FULL]  = 1'b0;
    end
    // transmitter: enable first, then disable/reset
    if (act.tx_on) begin
      status_d[ST_TXRDY] = 1'b1;
      status_d[ST_TXEMT] = 1'b1;
      tx_irq_d           = 1'b1;
    end
    if (act.tx_off) begin
      status_d[ST_TXRDY] = 1'b0;
      status_d[ST_TXEMT] = 1'b0;
      tx_irq_d           = 1'b0;
    end
    if (act.err_rst) status_d[ERR_HI:ST_ERR_LO] = '0;
    if (act.brk_rst) brk_irq_d = 1'b0;
    // events land after the clears so they are never lost
    status_d[ST_RXRDY]          = status_d[ST_RXRDY] | rx_set[0];
    status_d[ST_FULL]           = status_d[ST_FULL]  | rx_set[1];
    status_d[ERR_HI:ST_ERR_LO]  = status_d[ERR_HI:ST_ERR_LO] | err_set;
    if (brk_set) brk_irq_d = 1'b1;
  end

  assign upd_en = (|act) || (|rx_set) || (|err_set) || brk_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q  <= '0;
      rx_en_q   <= 1'b0;
      tx_irq_q  <= 1'b0;
      brk_irq_q <= 1'b0;
    end else if (upd_en) begin
      status_q  <= status_d;
      rx_en_q   <= rx_en_d;
      tx_irq_q  <= tx_irq_d;
      brk_irq_q <= brk_irq_d;
    end
  end
endmodule

// File: rtl/chan_mode_file.sv
module chan_mode_file #(
  parameter int DATA_W     = 8,
  parameter int MODE_DEPTH = 2,
  localparam int PTR_W     = (MODE_DEPTH > 1) ? $clog2(MODE_DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_we,
  input  logic                         acc_re,
  input  logic                         ptr_rst,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_byte,
  output logic [PTR_W-1:0]             ptr_q,
  output logic [MODE_DEPTH*DATA_W-1:0] mode_flat
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(MODE_DEPTH - 1);

  logic [DATA_W-1:0] mreg_q [MODE_DEPTH];
  logic [PTR_W-1:0]  ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = 1'b0;
    if (ptr_rst) begin
      ptr_d  = '0;
      ptr_en = 1'b1;
    end else if (acc_we || acc_re) begin
      ptr_d  = (ptr_q == LAST) ? LAST : ptr_q + PTR_W'(1);
      ptr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < MODE_DEPTH; g++) begin : g_mreg
    logic sel_en;
    assign sel_en = acc_we && (ptr_q == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mreg_q[g] <= '0;
      else if (sel_en) mreg_q[g] <= wr_data;
    end
    assign mode_flat[g*DATA_W +: DATA_W] = mreg_q[g];
  end

  assign rd_byte = mreg_q[ptr_q];
endmodule

// File: rtl/chan_tx_gate.sv
module chan_tx_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_we,
  input  logic              tx_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data
);
  logic accept;
  assign accept = hold_we && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_valid <= 1'b0;
    else        tx_valid <= accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tx_data <= '0;
    else if (accept) tx_data <= wr_data;
  end
endmodule

// File: rtl/uart_chan_ctrl.sv
module uart_chan_ctrl
  import chan_ctrl_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ERR_W      = 4,
  parameter int MODE_DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         rd_en,
  input  logic [1:0]                   reg_sel,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [DATA_W-1:0]            rd_data,
  input  logic [1:0]                   rx_set,
  input  logic [ERR_W-1:0]             err_set,
  input  logic                         brk_set,
  output logic                         rx_en,
  output logic                         tx_irq,
  output logic                         brk_irq,
  output logic [MODE_DEPTH*DATA_W-1:0] mode_cfg,
  output logic                         tx_valid,
  output logic [DATA_W-1:0]            tx_data
);
  localparam int PTR_W = (MODE_DEPTH > 1) ? $clog2(MODE_DEPTH) : 1;

  reg_sel_e          sel;
  cmd_act_t          act;
  logic [DATA_W-1:0] status_q;
  logic [DATA_W-1:0] mode_byte;
  logic [PTR_W-1:0]  ptr_q;
  logic              cmd_we, hold_we, mode_we, mode_re;

  assign sel     = reg_sel_e'(reg_sel);
  assign cmd_we  = wr_en && (sel == SEL_CMD);
  assign hold_we = wr_en && (sel == SEL_HOLD);
  assign mode_we = wr_en && (sel == SEL_MODE);
  assign mode_re = rd_en && (sel == SEL_MODE);

  chan_cmd_decode i_dec (
    .cmd_we   (cmd_we),
    .cmd_byte (wr_data),
    .act      (act)
  );

  chan_status #(.DATA_W(DATA_W), .ERR_W(ERR_W)) i_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .rx_set    (rx_set),
    .err_set   (err_set),
    .brk_set   (brk_set),
    .status_q  (status_q),
    .rx_en_q   (rx_en),
    .tx_irq_q  (tx_irq),
    .brk_irq_q (brk_irq)
  );

  chan_mode_file #(.DATA_W(DATA_W), .MODE_DEPTH(MODE_DEPTH)) i_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_we    (mode_we),
    .acc_re    (mode_re),
    .ptr_rst   (act.ptr_rst),
    .wr_data   (wr_data),
    .rd_byte   (mode_byte),
    .ptr_q     (ptr_q),
    .mode_flat (mode_cfg)
  );

  chan_tx_gate #(.DATA_W(DATA_W)) i_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_we  (hold_we),
    .tx_ready (status_q[ST_TXRDY]),
    .wr_data  (wr_data),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_MODE: rd_data = mode_byte;
        SEL_CMD:  rd_data = status_q;
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/chan_ctrl_chk.sv
module chan_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 4,
  parameter int PTR_W  = 1,
  parameter int LAST   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        reg_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [ERR_W-1:0]  err_set,
  input logic              rx_en,
  input logic              tx_irq,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic [DATA_W-1:0] status_q,
  input logic [PTR_W-1:0]  ptr_q
);
  logic cmd_w, hold_w, mode_acc;
  assign cmd_w    = wr_en && (reg_sel == 2'd1);
  assign hold_w   = wr_en && (reg_sel == 2'd2);
  assign mode_acc = (wr_en || rd_en) && (reg_sel == 2'd0);

  // R10
  tx_only_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> ($past(hold_w) && $past(status_q[2])));

  // R10
  tx_byte_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_w && status_q[2]) |=> (tx_valid && tx_data == $past(wr_data)));

  // R3
  tx_disable_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[3]) |=> (!status_q[2] && !status_q[3] && !tx_irq));

  // R2
  rx_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[0] && !wr_data[1] && wr_data[7:4] != 4'd2) |=> rx_en);

  // R4
  ptr_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_acc && !(cmd_w && wr_data[7:4] == 4'd1)) |=> (ptr_q == PTR_W'(LAST)));

  // R7
  err_clear_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w && wr_data[7:4] == 4'd4) |=> (status_q[7:4] == $past(err_set)));
endmodule

bind uart_chan_ctrl chan_ctrl_chk #(
  .DATA_W (DATA_W),
  .ERR_W  (ERR_W),
  .PTR_W  (PTR_W),
  .LAST   (MODE_DEPTH - 1)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .reg_sel  (reg_sel),
  .wr_data  (wr_data),
  .err_set  (err_set),
  .rx_en    (rx_en),
  .tx_irq   (tx_irq),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .status_q (status_q),
  .ptr_q    (ptr_q)
);

// File: tb/test_uart_chan_ctrl.sv
module test_uart_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [1:0]  reg_sel;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [1:0]  rx_set;
  logic [3:0]  err_set;
  logic        brk_set;
  logic        rx_en, tx_irq, brk_irq, tx_valid;
  logic [15:0] mode_cfg;
  logic [7:0]  tx_data;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rv;
  bit done = 0;

  always #5 clk = ~clk;

  uart_chan_ctrl i_uart_chan_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .rd_data(rd_data), .rx_set(rx_set), .err_set(err_set),
    .brk_set(brk_set), .rx_en(rx_en), .tx_irq(tx_irq), .brk_irq(brk_irq),
    .mode_cfg(mode_cfg), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every strobe must match the oldest expected byte
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 actual=%h expected=none", tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (tx_data !== e) begin
          fails++;
          $display("FAIL R10 actual=%h expected=%h", tx_data, e);
        end
      end
    end
  end

  task automatic bus_wr_ev(logic [1:0] sel, logic [7:0] d, logic [3:0] ev, logic bk);
    @(negedge clk);
    wr_en = 1'b1; reg_sel = sel; wr_data = d; err_set = ev; brk_set = bk;
    @(negedge clk);
    wr_en = 1'b0; err_set = '0; brk_set = 1'b0;
  endtask

  task automatic bus_wr(logic [1:0] sel, logic [7:0] d);
    bus_wr_ev(sel, d, 4'h0, 1'b0);
  endtask

  task automatic hold_wr(logic [7:0] d, bit expect_out);
    if (expect_out) exp_q.push_back(d);
    bus_wr(2'd2, d);
  endtask

  task automatic bus_rd(logic [1:0] sel, output logic [7:0] q);
    @(negedge clk);
    rd_en = 1'b1; reg_sel = sel;
    #1 q = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(logic [1:0] rx, logic [3:0] ev, logic bk);
    @(negedge clk);
    rx_set = rx; err_set = ev; brk_set = bk;
    @(negedge clk);
    rx_set = '0; err_set = '0; brk_set = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; reg_sel = 0; wr_data = 0;
    rx_set = 0; err_set = 0; brk_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(2'd1, rv);
    chk("R1 status", rv, 8'h00);
    chk("R1 flags", {rx_en, tx_irq, brk_irq}, 3'b000);

    // R10 drop while not ready
    hold_wr(8'h55, 0);
    // R3 enable TX
    bus_wr(2'd1, 8'h04);
    bus_rd(2'd1, rv);
    chk("R3 enable status", rv, 8'h0C);
    chk("R3 irq", tx_irq, 1'b1);
    // R10 back-to-back accepted bytes
    hold_wr(8'hA5, 1);
    hold_wr(8'h3C, 1);
    // R3 disable wins over enable
    bus_wr(2'd1, 8'h0C);
    bus_rd(2'd1, rv);
    chk("R3 disable wins", {tx_irq, rv}, 9'h000);
    hold_wr(8'h77, 0);

    // R2 receiver switching
    bus_wr(2'd1, 8'h01);
    chk("R2 rx on", rx_en, 1'b1);
    bus_wr(2'd1, 8'h03);
    chk("R2 off wins", rx_en, 1'b0);
    bus_wr(2'd1, 8'h01);

    // R12 / R5
    pulse(2'b11, 4'h0, 1'b0);
    bus_rd(2'd1, rv);
    chk("R12 rx bits", rv, 8'h03);
    bus_wr(2'd1, 8'h20);
    bus_rd(2'd1, rv);
    chk("R5 reset rx status", rv, 8'h00);
    chk("R5 rx off", rx_en, 1'b0);

    // R6 reset TX after enable in same byte
    bus_wr(2'd1, 8'h04);
    bus_wr(2'd1, 8'h34);
    bus_rd(2'd1, rv);
    chk("R6 reset tx", {tx_irq, rv}, 9'h000);

    // R12 / R7 error bits, clear racing with new event
    pulse(2'b00, 4'hF, 1'b0);
    bus_rd(2'd1, rv);
    chk("R12 err bits", rv, 8'hF0);
    bus_wr_ev(2'd1, 8'h40, 4'b0010, 1'b0);
    bus_rd(2'd1, rv);
    chk("R7 clear keeps new", rv, 8'h20);
    bus_wr(2'd1, 8'h40);
    bus_rd(2'd1, rv);
    chk("R7 clear", rv, 8'h00);

    // R8 break-change request
    pulse(2'b00, 4'h0, 1'b1);
    chk("R8 set", brk_irq, 1'b1);
    bus_wr(2'd1, 8'h50);
    chk("R8 clear", brk_irq, 1'b0);
    bus_wr_ev(2'd1, 8'h50, 4'h0, 1'b1);
    chk("R8 set wins", brk_irq, 1'b1);
    bus_wr(2'd1, 8'h50);
    chk("R8 clear again", brk_irq, 1'b0);

    // R4 mode pointer
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd0, 8'h22);
    bus_wr(2'd0, 8'h33);
    chk("R4 mode regs", mode_cfg, 16'h3311);
    bus_rd(2'd0, rv);
    chk("R4 read sticks", rv, 8'h33);
    bus_wr(2'd1, 8'h10);
    bus_rd(2'd0, rv);
    chk("R4 ptr reset", rv, 8'h11);
    bus_rd(2'd0, rv);
    chk("R4 advance", rv, 8'h33);

    // R9 unused codes
    bus_wr(2'd1, 8'h04);
    pulse(2'b00, 4'b1000, 1'b0);
    bus_wr(2'd1, 8'h01);
    bus_wr(2'd1, 8'h00);
    bus_wr(2'd1, 8'h60);
    bus_wr(2'd1, 8'h70);
    bus_wr(2'd1, 8'hA0);
    bus_wr(2'd1, 8'hF0);
    bus_rd(2'd1, rv);
    chk("R9 status", rv, 8'h8C);
    chk("R9 flags", {rx_en, tx_irq, brk_irq}, 3'b110);
    bus_rd(2'd0, rv);
    chk("R9 ptr", rv, 8'h33);

    // R11 ignored select and zero reads
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd1, rv);
    chk("R11 sel3 write", rv, 8'h8C);
    chk("R11 sel3 mode", mode_cfg, 16'h3311);
    bus_rd(2'd2, rv);
    chk("R11 read hold", rv, 8'h00);
    bus_rd(2'd3, rv);
    chk("R11 read none", rv, 8'h00);

    // R10 final accepted byte
    hold_wr(8'h5A, 1);
    repeat (3) @(negedge clk);
    chk("R10 queue drained", exp_q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule